// File: doc/BRIEF.md
# Half-Precision Vector Round-to-Integral Unit

This unit takes one 32-bit instruction word, a 128-bit vector of IEEE half-precision values, the global rounding-mode setting and the current sticky invalid and inexact flags. It decodes a small family of round-to-integral operations and rounds every active 16-bit lane to an integral value. The result stays in half-precision format. It returns the new vector, the updated sticky flags, a write-enable for the destination and an undefined-instruction indication.

Seven operation codes share one datapath. Five of them fix the rounding direction. The other two follow the global mode. Only the exact variant may raise the inexact flag. The unit never writes the global rounding mode, so a fixed-direction operation does not change it for later operations.

Operands enter on a valid/ready stream and results leave on a valid/ready stream, with one register stage between them. The input side applies back-pressure: `in_ready` goes low whenever a result is waiting and `out_ready` is low. While a result is stalled, it and its flags are held unchanged until the consumer accepts it. A new operand can be taken in the same cycle that the waiting result is accepted.

Top module: `fp16_rint_vec`

## Requirements
- R1: The 7-bit selector is {instr[29], instr[23], instr[16:12]} (instr[29] is the MSB). Any selector other than 0x18, 0x19, 0x38, 0x39, 0x58, 0x59 or 0x79 gives `out_undef`=1, `out_wr`=0, `out_data`=0, and the incoming flags are passed through unchanged.
- R2: Selector 0x18 rounds to nearest with ties to even. 0x19 rounds toward minus infinity. 0x38 rounds toward plus infinity. 0x39 rounds toward zero. 0x58 rounds to nearest with ties away from zero.
- R3: Selectors 0x59 and 0x79 use `in_rmode`, encoded as 0 = nearest-even, 1 = plus infinity, 2 = minus infinity, 3 = toward zero.
- R4: Only selector 0x59 ORs into `out_inx` when an active lane's result differs from its input. Every other selector passes `in_inx` through unchanged.
- R5: When instr[30]=1, all 8 lanes are processed. When instr[30]=0, only lanes 0..3 (bits 63:0) are processed. In that case `out_data[127:64]` is zero, and the upper lanes have no effect on the flags.
- R6: When instr[28]=1 (scalar form), the operation is undefined whatever instr[30] is, with the same outputs as in R1.
- R7: A lane passes through unchanged if it is an infinity, a zero, or has a biased exponent of 25 or more (unbiased exponent of 10 or more).
- R8: A signaling NaN lane (exponent all ones, mantissa bit 9 clear, mantissa nonzero) yields 0x7E00 and sets `out_inv`. A quiet NaN lane is returned unchanged and does not set `out_inv`.
- R9: The sign bit of each lane is always preserved. A negative value that rounds to zero yields 0x8000. A subnormal input rounds to a signed zero or a signed one, depending on the mode.
- R10: A synchronous active-high reset clears `out_valid`, `out_data` and all output flags. `in_ready` equals `!out_valid || out_ready`. A result that is not accepted keeps `out_valid` and all of its values stable.
- R11: The incoming flags are sticky. `out_inv` is at least `in_inv`, and `out_inx` is at least `in_inx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand presented |
| in_ready | output | 1 | Unit can take an operand |
| in_instr | input | 32 | Instruction word |
| in_src | input | 128 | Source vector, lane i at bits 16i+15:16i |
| in_rmode | input | 2 | Global rounding mode |
| in_inv | input | 1 | Current sticky invalid flag |
| in_inx | input | 1 | Current sticky inexact flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Rounded vector |
| out_inv | output | 1 | Updated invalid flag |
| out_inx | output | 1 | Updated inexact flag |
| out_undef | output | 1 | Undefined instruction |
| out_wr | output | 1 | Destination write enable |

## Verification
All state lives in one result register, so a fault shows at the ports in the cycle after the operand is accepted. A wrong decode appears at once as a wrong rounding direction on tie or fraction lanes, or as a spurious or missing undefined flag. A stalled result that drifts, or a handshake that drops a result, shows during the stall cycles as a changed `out_data` or a missing `out_valid`. Flag errors show on the same transfer as a lost sticky bit, an inexact from a non-exact selector, or an invalid coming from a masked upper lane.

// File: rtl/fprnd_pkg.sv
package fprnd_pkg;
  localparam int LANE_W = 16;

  typedef enum logic [2:0] {
    RND_NE = 3'd0,
    RND_PI = 3'd1,
    RND_MI = 3'd2,
    RND_ZR = 3'd3,
    RND_NA = 3'd4
  } rnd_e;

  localparam logic [6:0] SEL_NE  = 7'h18;
  localparam logic [6:0] SEL_MI  = 7'h19;
  localparam logic [6:0] SEL_PI  = 7'h38;
  localparam logic [6:0] SEL_ZR  = 7'h39;
  localparam logic [6:0] SEL_NA  = 7'h58;
  localparam logic [6:0] SEL_EXA = 7'h59;
  localparam logic [6:0] SEL_DYN = 7'h79;
endpackage

// File: rtl/fprnd_dec.sv
module fprnd_dec
  import fprnd_pkg::*;
(
  input  logic [31:0] instr,
  input  logic [1:0]  glob_rm,
  output rnd_e        mode,
  output logic        exact,
  output logic        wide,
  output logic        undef
);
  logic [6:0] sel;
  logic       known;
  rnd_e       dyn_mode;

  assign sel  = {instr[29], instr[23], instr[16:12]};
  assign wide = instr[30];

  always_comb begin
    case (glob_rm)
      2'd0:    dyn_mode = RND_NE;
      2'd1:    dyn_mode = RND_PI;
      2'd2:    dyn_mode = RND_MI;
      default: dyn_mode = RND_ZR;
    endcase
  end

  always_comb begin
    known = 1'b1;
    exact = 1'b0;
    mode  = RND_NE;
    case (sel)
      SEL_NE:  mode = RND_NE;
      SEL_MI:  mode = RND_MI;
      SEL_PI:  mode = RND_PI;
      SEL_ZR:  mode = RND_ZR;
      SEL_NA:  mode = RND_NA;
      SEL_EXA: begin mode = dyn_mode; exact = 1'b1; end
      SEL_DYN: mode = dyn_mode;
      default: known = 1'b0;
    endcase
  end

  assign undef = instr[28] || !known;
endmodule

// File: rtl/fprnd_lane.sv
module fprnd_lane
  import fprnd_pkg::*;
(
  input  logic [LANE_W-1:0] din,
  input  rnd_e              mode,
  output logic [LANE_W-1:0] dout,
  output logic              inv,
  output logic              inx
);
  localparam logic [4:0] EXP_INT = 5'd25;
  localparam logic [4:0] BIAS    = 5'd15;

  logic        sgn;
  logic [4:0]  ex;
  logic [9:0]  man;
  logic [4:0]  ex_eff;
  logic [10:0] sig;
  logic [4:0]  sh;
  logic [3:0]  rpos;
  logic [10:0] ipart;
  logic        rbit, stk, inc;
  logic [11:0] sum;
  logic [3:0]  lead;
  logic [11:0] norm;

  always_comb begin
    sgn    = din[15];
    ex     = din[14:10];
    man    = din[9:0];
    ex_eff = (ex == 5'd0) ? 5'd1 : ex;
    sig    = {ex != 5'd0, man};
    sh     = EXP_INT - ex_eff;
    rpos   = sh[3:0] - 4'd1;
    ipart  = '0;
    rbit   = 1'b0;
    stk    = 1'b0;
    inc    = 1'b0;
    sum    = '0;
    lead   = '0;
    norm   = '0;
    dout   = din;
    inv    = 1'b0;
    inx    = 1'b0;

    if (ex == 5'h1F) begin
      if (man != 10'd0 && !man[9]) begin
        dout = 16'h7E00;
        inv  = 1'b1;
      end
    end else if (ex >= EXP_INT || (ex == 5'd0 && man == 10'd0)) begin
      dout = din;
    end else begin
      if (sh <= 5'd11) begin
        ipart = sig >> sh;
        rbit  = sig[rpos];
        stk   = |(sig & ((11'd1 << rpos) - 11'd1));
      end else begin
        stk = 1'b1;
      end
      inx = rbit | stk;
      case (mode)
        RND_NE:  inc = rbit && (stk || ipart[0]);
        RND_NA:  inc = rbit;
        RND_PI:  inc = !sgn && inx;
        RND_MI:  inc = sgn && inx;
        default: inc = 1'b0;
      endcase
      sum = {1'b0, ipart} + {11'd0, inc};
      if (sum == 12'd0) begin
        dout = {sgn, 15'd0};
      end else begin
        for (int k = 0; k < 12; k++) begin
          if (sum[k]) lead = k[3:0];
        end
        norm = sum << (4'd10 - lead);
        dout = {sgn, BIAS + {1'b0, lead}, norm[9:0]};
      end
    end
  end
endmodule

// File: rtl/fp16_rint_vec.sv
module fp16_rint_vec
  import fprnd_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [31:0]              in_instr,
  input  logic [LANES*LANE_W-1:0]  in_src,
  input  logic [1:0]               in_rmode,
  input  logic                     in_inv,
  input  logic                     in_inx,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANES*LANE_W-1:0]  out_data,
  output logic                     out_inv,
  output logic                     out_inx,
  output logic                     out_undef,
  output logic                     out_wr
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int NARROW = LANES / 2;

  rnd_e              mode;
  logic              exact, wide, undef, accept;
  logic [LANES-1:0]  lane_en, lane_inv, lane_inx;
  logic [DATA_W-1:0] lane_res, nx_data;
  logic              nx_inv, nx_inx;

  fprnd_dec u_dec (
    .instr  (in_instr),
    .glob_rm(in_rmode),
    .mode   (mode),
    .exact  (exact),
    .wide   (wide),
    .undef  (undef)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    fprnd_lane u_lane (
      .din (in_src[i*LANE_W +: LANE_W]),
      .mode(mode),
      .dout(lane_res[i*LANE_W +: LANE_W]),
      .inv (lane_inv[i]),
      .inx (lane_inx[i])
    );
    assign lane_en[i] = (i < NARROW) || wide;
    assign nx_data[i*LANE_W +: LANE_W] =
      (lane_en[i] && !undef) ? lane_res[i*LANE_W +: LANE_W] : '0;
  end

  assign nx_inv   = in_inv | (!undef && |(lane_inv & lane_en));
  assign nx_inx   = in_inx | (!undef && exact && |(lane_inx & lane_en));
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_inv   <= 1'b0;
      out_inx   <= 1'b0;
      out_undef <= 1'b0;
      out_wr    <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= nx_data;
      out_inv   <= nx_inv;
      out_inx   <= nx_inx;
      out_undef <= undef;
      out_wr    <= !undef;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fprnd_chk.sv
module fprnd_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [31:0]       in_instr,
  input logic              in_inv,
  input logic              in_inx,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_inv,
  input logic              out_inx,
  input logic              out_undef,
  input logic              out_wr
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_inx)); // R10
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R10
  AST_UNDEF_NOWR: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_undef |-> !out_wr && out_data == '0); // R1
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !in_instr[30] |=> out_data[DATA_W-1:DATA_W/2] == '0); // R5
  AST_SCALAR_UNDEF: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_instr[28] |=> out_undef); // R6
  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> (out_inv || !$past(in_inv)) && (out_inx || !$past(in_inx))); // R11
endmodule

bind fp16_rint_vec fprnd_chk #(.DATA_W(LANES*fprnd_pkg::LANE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_instr(in_instr), .in_inv(in_inv), .in_inx(in_inx),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_inv(out_inv), .out_inx(out_inx), .out_undef(out_undef), .out_wr(out_wr)
);

// File: tb/fp16_rint_vec_test.sv
module fp16_rint_vec_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_instr = '0;
  logic [127:0] in_src = '0;
  logic [1:0]   in_rmode = '0;
  logic         in_inv = 1'b0;
  logic         in_inx = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         out_inv, out_inx, out_undef, out_wr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp16_rint_vec uut (.*);

  // lanes: 1.5 2.5 -1.5 0.5 -0.5 1.25 -1.25 0.25 (lane0 first)
  localparam logic [127:0] V_MIX = {16'h3400,16'hBD00,16'h3D00,16'hB800,16'h3800,16'hBE00,16'h4100,16'h3E00};
  localparam logic [127:0] E_NE  = {16'h0000,16'hBC00,16'h3C00,16'h8000,16'h0000,16'hC000,16'h4000,16'h4000};
  localparam logic [127:0] E_MI  = {16'h0000,16'hC000,16'h3C00,16'hBC00,16'h0000,16'hC000,16'h4000,16'h3C00};
  localparam logic [127:0] E_PI  = {16'h3C00,16'hBC00,16'h4000,16'h8000,16'h3C00,16'hBC00,16'h4200,16'h4000};
  localparam logic [127:0] E_ZR  = {16'h0000,16'hBC00,16'h3C00,16'h8000,16'h0000,16'hBC00,16'h4000,16'h3C00};
  localparam logic [127:0] E_NA  = {16'h0000,16'hBC00,16'h3C00,16'hBC00,16'h3C00,16'hC000,16'h4200,16'h4000};

  function automatic logic [31:0] mk(input logic [6:0] sel, input logic q, input logic scal);
    logic [31:0] w = '0;
    w[16:12] = sel[4:0];
    w[23] = sel[5];
    w[29] = sel[6];
    w[30] = q;
    w[28] = scal;
    return w;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [127:0] src,
                       input logic [1:0] rm, input logic fi, input logic fx);
    @(negedge clk);
    in_instr = ins; in_src = src; in_rmode = rm; in_inv = fi; in_inx = fx;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 valid", {127'd0, out_valid}, 128'd1);
  endtask

  task automatic t_reset();
    check("R10 reset valid", {127'd0, out_valid}, 128'd0);
    check("R10 reset data", out_data, 128'd0);
    check("R10 reset ready", {127'd0, in_ready}, 128'd1);
  endtask

  task automatic t_fixed();
    issue(mk(7'h18,1,0), V_MIX, 2'd3, 0, 0); check("R2 NE", out_data, E_NE);
    check("R4 no inx", {127'd0,out_inx}, 128'd0);
    check("R1 wr", {126'd0,out_wr,out_undef}, 128'd2);
    issue(mk(7'h19,1,0), V_MIX, 2'd0, 0, 0); check("R2 MI", out_data, E_MI);
    issue(mk(7'h38,1,0), V_MIX, 2'd0, 0, 0); check("R2 PI", out_data, E_PI);
    issue(mk(7'h39,1,0), V_MIX, 2'd0, 0, 0); check("R2 ZR", out_data, E_ZR);
    issue(mk(7'h58,1,0), V_MIX, 2'd0, 0, 0); check("R2 NA", out_data, E_NA);
  endtask

  task automatic t_dynamic();
    issue(mk(7'h79,1,0), V_MIX, 2'd1, 0, 0); check("R3 dyn PI", out_data, E_PI);
    check("R4 0x79 no inx", {127'd0,out_inx}, 128'd0);
    issue(mk(7'h79,1,0), V_MIX, 2'd3, 0, 0); check("R3 dyn ZR", out_data, E_ZR);
    issue(mk(7'h59,1,0), V_MIX, 2'd2, 0, 0); check("R3 exact MI", out_data, E_MI);
    check("R4 exact inx", {127'd0,out_inx}, 128'd1);
    issue(mk(7'h59,1,0), V_MIX, 2'd0, 0, 0); check("R3 exact NE", out_data, E_NE);
  endtask

  task automatic t_inexact();
    issue(mk(7'h59,1,0), {8{16'h4000}}, 2'd0, 0, 0);
    check("R4 exact integral", {127'd0,out_inx}, 128'd0);
    issue(mk(7'h18,1,0), V_MIX, 2'd0, 1, 1);
    check("R11 inx kept", {126'd0,out_inv,out_inx}, 128'd3);
  endtask

  task automatic t_special();
    logic [127:0] s = {16'h6000,16'h8001,16'h0001,16'h8000,16'hFE01,16'h7D00,16'h6400,16'h7C00};
    logic [127:0] e = {16'h6000,16'h8000,16'h3C00,16'h8000,16'hFE01,16'h7E00,16'h6400,16'h7C00};
    issue(mk(7'h38,1,0), s, 2'd0, 0, 0);
    check("R7 R8 R9 specials", out_data, e);
    check("R8 inv", {127'd0,out_inv}, 128'd1);
    issue(mk(7'h38,1,0), {8{16'hFE01}}, 2'd0, 0, 0);
    check("R8 qnan no inv", {127'd0,out_inv}, 128'd0);
    issue(mk(7'h19,1,0), {8{16'h0001}}, 2'd0, 0, 0);
    check("R9 subnormal MI", out_data, {8{16'h0000}});
  endtask

  task automatic t_narrow();
    logic [127:0] s = {16'h7D00,16'h7D00,16'h7D00,16'h7D00,16'h63FF,16'hB800,16'h4100,16'h3E00};
    issue(mk(7'h18,0,0), s, 2'd0, 0, 0);
    check("R5 narrow", out_data, {64'd0,16'h6400,16'h8000,16'h4000,16'h4000});
    check("R5 upper no inv", {127'd0,out_inv}, 128'd0);
  endtask

  task automatic t_undef();
    issue(mk(7'h18,1,1), V_MIX, 2'd0, 1, 0);
    check("R6 scalar", {125'd0,out_undef,out_wr,out_inv}, 128'd5);
    check("R6 scalar data", out_data, 128'd0);
    issue(mk(7'h18,0,1), V_MIX, 2'd0, 0, 0);
    check("R6 scalar narrow", {126'd0,out_undef,out_wr}, 128'd2);
    issue(mk(7'h1A,1,0), V_MIX, 2'd0, 0, 1);
    check("R1 bad sel", {125'd0,out_undef,out_wr,out_inx}, 128'd5);
  endtask

  task automatic t_stall();
    logic [127:0] held;
    @(negedge clk);
    in_instr = mk(7'h18,1,0); in_src = V_MIX; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    held = out_data;
    check("R10 stall data", held, E_NE);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 stall hold", {126'd0,out_valid,in_ready}, 128'd2);
      check("R10 stall stable", out_data, held);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R10 drained", {127'd0,out_valid}, 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fixed();
    t_dynamic();
    t_inexact();
    t_special();
    t_narrow();
    t_undef();
    t_stall();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule